// File: doc/BRIEF.md
# Single-Word Interprocessor Mailbox

This block lets one processor hand a data word to another processor that runs at a different speed. The sender pulses a write strobe with a word on its data bus. That word is latched into a holding register, and a ready flag is raised in the same clock edge. The receiver polls the ready flag. When the flag is high, the receiver pulses a read strobe to take the word, and the flag drops. The sender polls a full output, which always matches the ready flag, so it can hold off until the previous word has been consumed.

Both sides share one clock, and every strobe is a single-cycle pulse. Misuse is reported, not blocked. If the sender writes over a word that has not been read, a sticky overrun flag is set, and it stays set until the sender pulses a clear input. If the receiver reads while nothing is pending, a one-cycle underrun pulse is raised and the stale word is left where it is. To build a return path, place a second instance with its roles swapped.

Top module: `mbx_mailbox`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following edge leaves `data_ready`, `full`, `overrun` and `underrun` at 0 and `rd_data` at all zeros.
- R2: A `wr_stb` pulse at a clock edge loads `wr_data` into the register, so `rd_data` shows that word after the edge, and it sets `data_ready` at the same edge.
- R3: A `rd_stb` pulse with no `wr_stb` while `data_ready` is 1 clears `data_ready` at that edge. `rd_data` is combinational from the register and shows the stored word during the strobe cycle.
- R4: When `wr_stb` and `rd_stb` are high in the same cycle, `rd_data` during that cycle is the previously stored word. After the edge, `rd_data` is the new word and `data_ready` is 1.
- R5: In a cycle with neither strobe, `data_ready` and `rd_data` keep their values.
- R6: A `wr_stb` with no `rd_stb` while `data_ready` is already 1 sets `overrun` at that edge. A write that is accompanied by a read does not set it.
- R7: `overrun` stays at 1 until an `ovr_clr` pulse clears it. If `ovr_clr` arrives in the same cycle as a new overrun event, `overrun` stays at 1.
- R8: A `rd_stb` while `data_ready` is 0 (and no `wr_stb`) leaves `data_ready` and `rd_data` unchanged. It raises `underrun` for exactly the one cycle after that edge.
- R9: `full` equals `data_ready` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Sender write pulse |
| wr_data | input | DATA_W | Word to send |
| ovr_clr | input | 1 | Sender pulse to clear overrun |
| full | output | 1 | Sender-side copy of the ready flag |
| overrun | output | 1 | Sticky: unread word was overwritten |
| rd_stb | input | 1 | Receiver read pulse |
| rd_data | output | DATA_W | Stored word |
| data_ready | output | 1 | Receiver-side pending flag |
| underrun | output | 1 | One-cycle pulse after a read with nothing pending |

## Verification
The bench targets the case where both strobes arrive in the same cycle. A design that lets the read win there would drop the flag and lose a fresh word. A design that samples data after the edge would return the new word instead of the old one. The bench also checks that a write coinciding with a read raises no overrun, and that a clear arriving together with an overrun event leaves the flag set; a design with the wrong priority would silently lose the error. Reads on an empty mailbox are checked to leave both the flag and the word untouched, so a design that toggles the flag on every read is caught.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the mailbox.
// Assumes: a single clock; strobes last one cycle.
package mbx_pkg;
    // Strobe bundle, sampled at one clock edge.
    typedef struct packed {
        logic put;   // sender writes
        logic take;  // receiver reads
        logic wipe;  // sender clears the overrun flag
    } mbx_req_t;

    // Classifies what a request does to the pending flag.
    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_FILL  = 2'd1,
        EV_DRAIN = 2'd2,
        EV_STRAY = 2'd3
    } mbx_evt_e;
endpackage

// File: rtl/mbx_word_reg.sv
`timescale 1ns/1ps
// Module: mbx_word_reg
// Holds the mailbox word. It loads on a put pulse and otherwise holds.
// Assumes: synchronous active-low reset that clears the word to zero.
module mbx_word_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] word_q;

    // Storage: clears on reset, captures din on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (load)
            word_q <= din;
    end

    assign dout = word_q;

    AST_WORD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (load && rst_n) |=> (dout == $past(din)));                 // R2
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && rst_n) |=> $stable(dout));                        // R5
endmodule

// File: rtl/mbx_flag_ctrl.sv
`timescale 1ns/1ps
// Module: mbx_flag_ctrl
// Keeps the pending flag. A put sets it; a take without a put clears it.
// When a put and a take arrive together, the put wins. The module also
// reports overrun and stray-take events to the error tracker.
// Assumes: put and take are single-cycle pulses.
module mbx_flag_ctrl
    import mbx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  mbx_req_t req,
    output logic     pending,
    output logic     ovr_evt,
    output logic     stray_evt
);
    logic     pend_q;
    mbx_evt_e evt;

    // Classification: decides how the request affects the flag.
    always_comb begin
        if (req.put)
            evt = EV_FILL;
        else if (req.take && pend_q)
            evt = EV_DRAIN;
        else if (req.take)
            evt = EV_STRAY;
        else
            evt = EV_IDLE;
    end

    // Flag register: set on fill, cleared on drain, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (evt == EV_FILL)
            pend_q <= 1'b1;
        else if (evt == EV_DRAIN)
            pend_q <= 1'b0;
    end

    // Event outputs: an overwrite of an unread word, and a read with nothing pending.
    assign ovr_evt   = (evt == EV_FILL) && pend_q && !req.take;
    assign stray_evt = (evt == EV_STRAY);
    assign pending   = pend_q;

    AST_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (req.put && rst_n) |=> pending);                            // R2
    AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (req.take && !req.put && rst_n) |=> !pending);              // R3
    AST_BOTH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req.take && req.put && rst_n) |=> pending);                // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!req.take && !req.put && rst_n) |=> $stable(pending));     // R5
endmodule

// File: rtl/mbx_err_track.sv
`timescale 1ns/1ps
// Module: mbx_err_track
// Keeps the sticky overrun flag and registers the one-cycle underrun pulse.
// Assumes: the events arrive from mbx_flag_ctrl in the cycle they occur.
module mbx_err_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_evt,
    input  logic stray_evt,
    input  logic wipe,
    output logic overrun,
    output logic underrun
);
    logic ovr_q;
    logic und_q;

    // Sticky overrun: a new event beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_q <= 1'b0;
        else if (ovr_evt)
            ovr_q <= 1'b1;
        else if (wipe)
            ovr_q <= 1'b0;
    end

    // Underrun pulse: high for the one cycle after a stray read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            und_q <= 1'b0;
        else
            und_q <= stray_evt;
    end

    assign overrun  = ovr_q;
    assign underrun = und_q;

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && rst_n) |=> overrun);                            // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !wipe) |=> overrun);                            // R7
    AST_UND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stray_evt && rst_n) |=> !underrun);                       // R8
endmodule

// File: rtl/mbx_mailbox.sv
`timescale 1ns/1ps
// Module: mbx_mailbox (top)
// A one-word mailbox between a sender and a receiver. It contains the word
// register, the pending-flag control and the error tracker.
// Assumes: one shared clock; all strobes are single-cycle pulses.
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ovr_clr,
    output logic              full,
    output logic              overrun,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              data_ready,
    output logic              underrun
);
    mbx_req_t req;
    logic     pending;
    logic     ovr_evt;
    logic     stray_evt;

    // Request bundle: groups the strobes for the submodules.
    always_comb begin
        req.put  = wr_stb;
        req.take = rd_stb;
        req.wipe = ovr_clr;
    end

    mbx_word_reg #(.DATA_W(DATA_W)) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (req.put),
        .din   (wr_data),
        .dout  (rd_data)
    );

    mbx_flag_ctrl u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .pending   (pending),
        .ovr_evt   (ovr_evt),
        .stray_evt (stray_evt)
    );

    mbx_err_track u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovr_evt   (ovr_evt),
        .stray_evt (stray_evt),
        .wipe      (req.wipe),
        .overrun   (overrun),
        .underrun  (underrun)
    );

    assign data_ready = pending;
    assign full       = pending;

    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (!data_ready && !overrun && !underrun && rd_data == '0)); // R1
    AST_STRAY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && !data_ready && rst_n) |=> (!data_ready && $stable(rd_data))); // R8
endmodule

// File: tb/sim_mbx_mailbox.sv
`timescale 1ns/1ps
// Bench for mbx_mailbox: directed corner cases followed by seeded random traffic.
module sim_mbx_mailbox;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_stb, rd_stb, ovr_clr;
    logic [W-1:0] wr_data;
    logic         full, overrun, data_ready, underrun;
    logic [W-1:0] rd_data;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // Bench model of the block, built from the requirements.
    logic [W-1:0] m_data;
    logic         m_rdy, m_ovr, m_und;

    always #2.5 clk = ~clk;

    mbx_mailbox #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .ovr_clr(ovr_clr), .full(full), .overrun(overrun), .rd_stb(rd_stb),
        .rd_data(rd_data), .data_ready(data_ready), .underrun(underrun)
    );

    // Next ready flag: a write sets it (R2, R4), a read alone clears it (R3).
    function automatic logic f_rdy(logic r, logic w, logic d);
        if (w) return 1'b1;
        if (d) return 1'b0;
        return r;
    endfunction

    // Next overrun: an unread overwrite sets it and beats a clear (R6, R7).
    function automatic logic f_ovr(logic o, logic r, logic w, logic d, logic c);
        if (w && r && !d) return 1'b1;
        if (c) return 1'b0;
        return o;
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive inputs at the falling edge, check combinational read data,
    // advance the model at the rising edge, then check the registered outputs.
    task automatic step(logic w, logic [W-1:0] d, logic r, logic c);
        wr_stb = w; wr_data = d; rd_stb = r; ovr_clr = c;
        #1;
        chk("R4 rd_data before edge", rd_data, m_data);
        @(posedge clk);
        m_und  = r && !w && !m_rdy;
        m_ovr  = f_ovr(m_ovr, m_rdy, w, r, c);
        m_rdy  = f_rdy(m_rdy, w, r);
        if (w) m_data = d;
        @(negedge clk);
        chk("R2/R5 rd_data", rd_data, m_data);
        chk("R3 data_ready", {7'd0, data_ready}, {7'd0, m_rdy});
        chk("R9 full", {7'd0, full}, {7'd0, data_ready});
        chk("R6/R7 overrun", {7'd0, overrun}, {7'd0, m_ovr});
        chk("R8 underrun", {7'd0, underrun}, {7'd0, m_und});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_stb = 0; rd_stb = 0; ovr_clr = 0; wr_data = 8'hA5;
        @(negedge clk); wr_stb = 1; rd_stb = 1; ovr_clr = 1;
        @(negedge clk); @(negedge clk);
        // R1: reset leaves everything cleared, even with strobes applied.
        chk("R1 data_ready", {7'd0, data_ready}, 8'd0);
        chk("R1 overrun", {7'd0, overrun}, 8'd0);
        chk("R1 underrun", {7'd0, underrun}, 8'd0);
        chk("R1 rd_data", rd_data, 8'd0);
        m_data = '0; m_rdy = 0; m_ovr = 0; m_und = 0;
        wr_stb = 0; rd_stb = 0; ovr_clr = 0;
        rst_n = 1'b1;

        step(0, 8'h00, 1, 0);   // R8 read on an empty mailbox
        step(0, 8'h00, 0, 0);   // R8 pulse lasts one cycle
        step(1, 8'h3C, 0, 0);   // R2 write
        step(0, 8'h00, 0, 0);   // R5 idle
        step(0, 8'h00, 1, 0);   // R3 read
        step(1, 8'h11, 0, 0);
        step(1, 8'h22, 1, 0);   // R4 both strobes; no overrun
        step(1, 8'h33, 0, 0);   // R6 overwrite of an unread word
        step(0, 8'h00, 0, 0);   // R7 sticky
        step(1, 8'h44, 0, 1);   // R7 set wins over clear
        step(0, 8'h00, 0, 1);   // R7 clear
        step(0, 8'h00, 1, 0);
        step(0, 8'h00, 1, 0);   // R8 stray read keeps the word

        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 10) < 4, W'($urandom), ($urandom % 10) < 4,
                 ($urandom % 10) < 1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule